// File: doc/BRIEF.md
# Scanline Display Timing Generator

This block is the timing source for a 240-pixel display. It counts dot-clock cycles within each scanline and counts scanlines within each frame. It reports the current line number, a horizontal-blank flag and a vertical-blank flag. It also compares each new line number against a programmable trigger value and keeps a coincidence flag.

Each line is split into two phases. The active phase is 960 cycles long and the horizontal-blank phase is 272 cycles long. Both phases occur on every line, including the vertical-blank lines. A frame has 228 lines. Lines 0 to 159 are visible, and lines 160 to 227 are vertical blank. A renderer receives a one-cycle draw strobe at the start of each visible line.

Three one-cycle interrupt request pulses are provided: horizontal blank, vertical blank and line coincidence. Each pulse is gated by its own enable bit in a 16-bit status/control word. Software writes that word through a simple write strobe, and the block always presents it on an output. Any phase length, line count or width can be changed through a parameter.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset the block is in the active phase of line 0 with dot count 0. The line number, all three flags, all three interrupt pulses and every control field of the status word are zero.
- R2: Each line runs ACTIVE_CYCLES active cycles and then BLANK_CYCLES blank cycles. The horizontal-blank flag is 1 during the blank cycles of every line and 0 during the active cycles.
- R3: The line number advances by one on the clock edge that ends a blank phase. It wraps from TOTAL_LINES-1 to 0 and never reaches TOTAL_LINES.
- R4: When bit 4 (hblank enable) is 1, a one-cycle hblank interrupt pulse appears in the first blank cycle of every line.
- R5: The vertical-blank flag becomes 1 when the line number becomes VISIBLE_LINES. It becomes 0 when the line number becomes TOTAL_LINES-1, so the flag reads 0 on the last line and on all visible lines.
- R6: When bit 3 (vblank enable) is 1, a one-cycle vblank interrupt pulse appears in the first cycle of line VISIBLE_LINES.
- R7: At every change of the line number, the coincidence flag is loaded with (new line == trigger value in bits 15:8). Between changes the flag keeps its value. After reset it stays 0 until the first change.
- R8: When bit 5 (coincidence enable) is 1, a one-cycle coincidence interrupt pulse appears in the first cycle of every line whose number equals the trigger value.
- R9: The draw strobe is 1 for exactly the first active cycle of every visible line, including line 0 right after reset.
- R10: The status word reads as follows. Bit 0 is vblank flag, bit 1 is hblank flag, bit 2 is coincidence flag, bit 3 is vblank enable, bit 4 is hblank enable, bit 5 is coincidence enable, and bits 15:8 are the trigger. Bits 7:6 read 0. A write loads only bits 5:3 and 15:8, and write data in bits 2:0 and 7:6 has no effect.
- R11: A trigger value of TOTAL_LINES or more never matches, so neither the coincidence flag nor its interrupt is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Write strobe for the control fields |
| ctrlWrData | input | 16 | Write data in status-word layout |
| statusReg | output | 16 | Flags, enables and trigger value |
| scanLine | output | $clog2(TOTAL_LINES) | Current line number |
| hblankFlag | output | 1 | Horizontal-blank status |
| vblankFlag | output | 1 | Vertical-blank status |
| matchFlag | output | 1 | Line coincidence status |
| hblankIrq | output | 1 | One-cycle hblank interrupt request |
| vblankIrq | output | 1 | One-cycle vblank interrupt request |
| matchIrq | output | 1 | One-cycle coincidence interrupt request |
| drawLineStrobe | output | 1 | One-cycle start-of-visible-line strobe |

## Verification
A wrong dot count or a wrong phase moves the hblank edge and the line increment. Such a fault shows at the ports within the same line, because every flag and pulse is predicted for every cycle from the cycle number alone. A wrong line counter or a wrong boundary compare shows up later, within one frame, as a vblank edge, interrupt or draw strobe on the wrong line. The bench checks every cycle of two full frames in a reduced configuration, once for each trigger value, including values past the last line, and for several enable patterns. As a result, a fault on any single line cannot go unseen.

// File: rtl/scan_timing_pkg.sv
`timescale 1ns/1ps
package scan_timing_pkg;

  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_BLANK  = 1'b1
  } phase_t;

  // Strobes from the dot sequencer to the line datapath, one cycle each.
  typedef struct packed {
    logic blankStart;   // next edge enters the blank phase
    logic lineEnd;      // next edge ends the blank phase and the line
    logic activeFirst;  // current cycle is the first active cycle
  } timing_strobe_t;

  localparam int TRIG_W   = 8;
  localparam int STATUS_W = 16;

endpackage

// File: rtl/scan_timing_ctrl.sv
`timescale 1ns/1ps
module scan_timing_ctrl
  import scan_timing_pkg::*;
#(
  parameter int ACTIVE_CYCLES = 960,
  parameter int BLANK_CYCLES  = 272
) (
  input  logic           clk,
  input  logic           rst_n,
  output timing_strobe_t strobe
);

  localparam int DOT_MAX = (ACTIVE_CYCLES > BLANK_CYCLES) ? ACTIVE_CYCLES : BLANK_CYCLES;
  localparam int DOT_W   = (DOT_MAX > 1) ? $clog2(DOT_MAX) : 1;
  localparam logic [DOT_W-1:0] ACTIVE_LAST = DOT_W'(ACTIVE_CYCLES - 1);
  localparam logic [DOT_W-1:0] BLANK_LAST  = DOT_W'(BLANK_CYCLES - 1);

  phase_t           phase;
  logic [DOT_W-1:0] dotCnt;
  logic             phaseDone;

  always_comb begin
    phaseDone = (phase == PH_ACTIVE) ? (dotCnt == ACTIVE_LAST)
                                     : (dotCnt == BLANK_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ACTIVE;
      dotCnt <= '0;
    end else if (phaseDone) begin
      phase  <= (phase == PH_ACTIVE) ? PH_BLANK : PH_ACTIVE;
      dotCnt <= '0;
    end else begin
      dotCnt <= dotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.blankStart  = phaseDone && (phase == PH_ACTIVE);
    strobe.lineEnd     = phaseDone && (phase == PH_BLANK);
    strobe.activeFirst = (phase == PH_ACTIVE) && (dotCnt == '0);
  end

endmodule

// File: rtl/scan_timing_datapath.sv
`timescale 1ns/1ps
module scan_timing_datapath
  import scan_timing_pkg::*;
#(
  parameter int VISIBLE_LINES = 160,
  parameter int TOTAL_LINES   = 228,
  parameter int LINE_W        = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  timing_strobe_t    strobe,
  input  logic              wrEn,
  input  logic [TRIG_W-1:0] wrTrigger,
  input  logic              wrVblankEn,
  input  logic              wrHblankEn,
  input  logic              wrMatchEn,
  output logic [LINE_W-1:0] lineNum,
  output logic [TRIG_W-1:0] trigger,
  output logic              vblankEn,
  output logic              hblankEn,
  output logic              matchEn,
  output logic              hblank,
  output logic              vblank,
  output logic              match,
  output logic              hIrq,
  output logic              vIrq,
  output logic              mIrq,
  output logic              drawStart
);

  localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(TOTAL_LINES - 1);
  localparam logic [LINE_W-1:0] VBL_LINE   = LINE_W'(VISIBLE_LINES);

  logic [LINE_W-1:0] nextLine;
  logic              nextHit;

  always_comb begin
    nextLine = (lineNum == LAST_LINE) ? '0 : lineNum + 1'b1;
    nextHit  = (TRIG_W'(nextLine) == trigger);
  end

  // Control fields written by software.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigger  <= '0;
      vblankEn <= 1'b0;
      hblankEn <= 1'b0;
      matchEn  <= 1'b0;
    end else if (wrEn) begin
      trigger  <= wrTrigger;
      vblankEn <= wrVblankEn;
      hblankEn <= wrHblankEn;
      matchEn  <= wrMatchEn;
    end
  end

  // Line counter, status flags and interrupt pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineNum <= '0;
      hblank  <= 1'b0;
      vblank  <= 1'b0;
      match   <= 1'b0;
      hIrq    <= 1'b0;
      vIrq    <= 1'b0;
      mIrq    <= 1'b0;
    end else begin
      hIrq <= 1'b0;
      vIrq <= 1'b0;
      mIrq <= 1'b0;
      if (strobe.blankStart) begin
        hblank <= 1'b1;
        hIrq   <= hblankEn;
      end
      if (strobe.lineEnd) begin
        hblank  <= 1'b0;
        lineNum <= nextLine;
        match   <= nextHit;
        mIrq    <= nextHit && matchEn;
        if (nextLine == VBL_LINE) begin
          vblank <= 1'b1;
          vIrq   <= vblankEn;
        end
        if (nextLine == LAST_LINE) begin
          vblank <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    drawStart = strobe.activeFirst && (lineNum < VBL_LINE);
  end

endmodule

// File: rtl/scan_timing_gen.sv
`timescale 1ns/1ps
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int ACTIVE_CYCLES = 960,
  parameter int BLANK_CYCLES  = 272,
  parameter int VISIBLE_LINES = 160,
  parameter int TOTAL_LINES   = 228,
  localparam int LINE_W       = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  output logic [15:0]       statusReg,
  output logic [LINE_W-1:0] scanLine,
  output logic              hblankFlag,
  output logic              vblankFlag,
  output logic              matchFlag,
  output logic              hblankIrq,
  output logic              vblankIrq,
  output logic              matchIrq,
  output logic              drawLineStrobe
);

  timing_strobe_t    strobe;
  logic [TRIG_W-1:0] trigger;
  logic              vblankEn;
  logic              hblankEn;
  logic              matchEn;
  logic              ctrlUnused;

  assign ctrlUnused = ^{ctrlWrData[7:6], ctrlWrData[2:0]};

  scan_timing_ctrl #(
    .ACTIVE_CYCLES(ACTIVE_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe)
  );

  scan_timing_datapath #(
    .VISIBLE_LINES(VISIBLE_LINES),
    .TOTAL_LINES  (TOTAL_LINES),
    .LINE_W       (LINE_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrEn      (ctrlWrEn),
    .wrTrigger (ctrlWrData[15:8]),
    .wrVblankEn(ctrlWrData[3]),
    .wrHblankEn(ctrlWrData[4]),
    .wrMatchEn (ctrlWrData[5]),
    .lineNum   (scanLine),
    .trigger   (trigger),
    .vblankEn  (vblankEn),
    .hblankEn  (hblankEn),
    .matchEn   (matchEn),
    .hblank    (hblankFlag),
    .vblank    (vblankFlag),
    .match     (matchFlag),
    .hIrq      (hblankIrq),
    .vIrq      (vblankIrq),
    .mIrq      (matchIrq),
    .drawStart (drawLineStrobe)
  );

  assign statusReg = {trigger, 2'b00, matchEn, hblankEn, vblankEn,
                      matchFlag, hblankFlag, vblankFlag};

endmodule

// File: rtl/scan_timing_chk.sv
`timescale 1ns/1ps
module scan_timing_chk #(
  parameter int VISIBLE_LINES = 160,
  parameter int TOTAL_LINES   = 228,
  parameter int LINE_W        = $clog2(TOTAL_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] scanLine,
  input logic              hblankFlag,
  input logic              vblankFlag,
  input logic              matchFlag,
  input logic              hblankIrq,
  input logic              vblankIrq,
  input logic              matchIrq,
  input logic              drawLineStrobe
);

  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scanLine) < TOTAL_LINES);

  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scanLine != $past(scanLine)) |->
      ((int'(scanLine) == int'($past(scanLine)) + 1) ||
       (scanLine == '0 && int'($past(scanLine)) == TOTAL_LINES - 1)));

  assert_line_at_blank_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scanLine != $past(scanLine)) |-> $fell(hblankFlag));

  assert_hirq_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hblankIrq |-> (hblankFlag && !$past(hblankFlag)));

  assert_hirq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hblankIrq |=> !hblankIrq);

  assert_vflag_last_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scanLine) == TOTAL_LINES - 1) |-> !vblankFlag);

  assert_virq_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vblankIrq |-> (vblankFlag && int'(scanLine) == VISIBLE_LINES));

  assert_mirq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    matchIrq |-> matchFlag);

  assert_draw_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drawLineStrobe |-> (int'(scanLine) < VISIBLE_LINES && !hblankFlag));

endmodule

bind scan_timing_gen scan_timing_chk #(
  .VISIBLE_LINES(VISIBLE_LINES),
  .TOTAL_LINES  (TOTAL_LINES),
  .LINE_W       (LINE_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .scanLine      (scanLine),
  .hblankFlag    (hblankFlag),
  .vblankFlag    (vblankFlag),
  .matchFlag     (matchFlag),
  .hblankIrq     (hblankIrq),
  .vblankIrq     (vblankIrq),
  .matchIrq      (matchIrq),
  .drawLineStrobe(drawLineStrobe)
);

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
module scan_timing_gen_tb_top;

  localparam int A  = 8;
  localparam int B  = 4;
  localparam int V  = 5;
  localparam int N  = 8;
  localparam int L  = A + B;
  localparam int LW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [15:0]   ctrlWrData = '0;
  logic [15:0]   statusReg;
  logic [LW-1:0] scanLine;
  logic          hblankFlag, vblankFlag, matchFlag;
  logic          hblankIrq, vblankIrq, matchIrq, drawLineStrobe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scan_timing_gen #(
    .ACTIVE_CYCLES(A), .BLANK_CYCLES(B), .VISIBLE_LINES(V), .TOTAL_LINES(N)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statusReg(statusReg), .scanLine(scanLine), .hblankFlag(hblankFlag),
    .vblankFlag(vblankFlag), .matchFlag(matchFlag), .hblankIrq(hblankIrq),
    .vblankIrq(vblankIrq), .matchIrq(matchIrq), .drawLineStrobe(drawLineStrobe)
  );

  task automatic chk(string req, string what, int t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s t=%0d actual=%0h expected=%0h", req, what, t, act, exp);
    end
  endtask

  task automatic runCase(int trig, bit ev, bit eh, bit em, int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    ctrlWrEn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // Read-only and reserved bits are set on purpose: R10 says they are ignored.
    ctrlWrData = {trig[7:0], 2'b11, em, eh, ev, 3'b111};
    ctrlWrEn = 1'b1;
    for (int t = 0; t <= cycles; t++) begin
      int line = (t / L) % N;
      int pos  = t % L;
      bit hb   = (pos >= A);
      bit vb   = (line >= V) && (line < N - 1);
      bit mf   = (t >= L) && (line == trig);
      bit hi   = eh && (pos == A);
      bit vi   = ev && (t > 0) && (pos == 0) && (line == V);
      bit mi   = em && (t > 0) && (pos == 0) && (line == trig);
      bit dr   = (pos == 0) && (line < V);
      logic [15:0] st;
      string mreq;
      st = (t == 0) ? {13'd0, mf, hb, vb}
                    : {trig[7:0], 2'b00, em, eh, ev, mf, hb, vb};
      mreq = (trig >= N) ? "R11" : "R7";
      if (t == 0) begin
        chk("R1", "reset line", t, 32'(scanLine), 0);
        chk("R1", "reset status", t, 32'(statusReg), 0);
        chk("R1", "reset irqs", t, {29'd0, hblankIrq, vblankIrq, matchIrq}, 0);
      end
      chk("R3", "scanLine", t, 32'(scanLine), 32'(line));
      chk("R2", "hblankFlag", t, 32'(hblankFlag), 32'(hb));
      chk("R5", "vblankFlag", t, 32'(vblankFlag), 32'(vb));
      chk(mreq, "matchFlag", t, 32'(matchFlag), 32'(mf));
      chk("R4", "hblankIrq", t, 32'(hblankIrq), 32'(hi));
      chk("R6", "vblankIrq", t, 32'(vblankIrq), 32'(vi));
      chk((trig >= N) ? "R11" : "R8", "matchIrq", t, 32'(matchIrq), 32'(mi));
      chk("R9", "drawLineStrobe", t, 32'(drawLineStrobe), 32'(dr));
      chk("R10", "statusReg", t, 32'(statusReg), 32'(st));
      @(posedge clk);
      @(negedge clk);
      ctrlWrEn = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int trig = 0; trig < N + 2; trig++) begin
      for (int pat = 0; pat < 4; pat++) begin
        bit ev = (pat == 1) || (pat == 2);
        bit eh = (pat == 1) || (pat == 3);
        bit em = (pat == 1) || (pat == 2);
        runCase(trig, ev, eh, em, 2 * N * L + 3);
      end
    end
    // Trigger far above the last line: R11 no coincidence ever.
    runCase(255, 1'b1, 1'b1, 1'b1, 2 * N * L + 3);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule